// File: doc/BRIEF.md
# Asynchronous SRAM Strobe Sequencer

This block sits between a clocked host and an external asynchronous static RAM of 16384 words of 4 bits. The host hands over one access at a time: a 14-bit word address, a read/write flag and, for writes, a 4-bit data word. The block turns each accepted access into a strobe sequence on the RAM pins that respects the RAM's ordering rules. The address moves only while the RAM is deselected. A write is the window in which chip select and write enable are both low. The block's own data drivers stay off whenever the RAM may be driving the bus. Each access ends with a deselected gap, so that the next one starts from a clean state.

Every nanosecond limit of the RAM becomes a cycle-count parameter, rounded up at the chosen clock period:

| Parameter | Covers |
|---|---|
| `SETUP_CYC` | address setup while deselected |
| `WP_CYC` | write window width, also covering data setup |
| `RD_CYC` | read access time |
| `REC_CYC` | write recovery |
| `TA_CYC` | read-to-idle bus turnaround |

The request side is valid/ready. An access is taken on a clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the host must hold `req_valid` and its payload steady. Read data returns as a single-cycle `rsp_valid` pulse with no back-pressure, so the host must take it in that cycle. RAM pins are active-low: a low `sram_cs_n` selects the RAM, and a low `sram_we_n` together with it writes.

Top module: `sram_async_ctrl`

## Requirements
- R1: `req_ready` is high exactly when no access is in progress. An access is accepted only on an edge where `req_valid` and `req_ready` are both high. A request held while `req_ready` is low leaves every RAM pin unchanged. `req_ready` falls in the cycle after acceptance and stays low until the last cycle of recovery or turnaround has passed.
- R2: In the `SETUP_CYC` cycles after acceptance, `sram_addr` carries the accepted address while `sram_cs_n` and `sram_we_n` are both 1. The address never changes in any other cycle.
- R3: `sram_addr` does not change in any cycle in which `sram_cs_n` was 0 in the previous cycle and is 0 now.
- R4: For a write, `sram_cs_n` and `sram_we_n` fall on the same edge, stay 0 together for exactly `WP_CYC` cycles and rise on the same edge. `sram_we_n` is never 0 while `sram_cs_n` is 1.
- R5: `sram_dq_oe` is 1 during every write-window cycle and in the one cycle after it, and is 0 otherwise. Whenever it is 1, `sram_dq_out` equals the accepted write data. It is never 1 while `sram_cs_n` is 0 and `sram_we_n` is 1.
- R6: After a write window, the RAM stays deselected (`sram_cs_n` = 1, `sram_we_n` = 1) for `REC_CYC` cycles, with the address held, before `req_ready` returns.
- R7: For a read, `sram_cs_n` is 0 and `sram_we_n` is 1 for exactly `RD_CYC` cycles. `sram_dq_in` is sampled on the edge that ends the last of these cycles.
- R8: Each read produces exactly one `rsp_valid` cycle, the cycle right after the read window, with `rsp_rdata` equal to the word last written to that address (0 if never written). Writes produce no `rsp_valid`.
- R9: After a read window, the RAM stays deselected for `TA_CYC` cycles, with the address held, before `req_ready` returns.
- R10: While `rst_n` is 0, after one clock edge: `sram_cs_n` = 1, `sram_we_n` = 1, `sram_dq_oe` = 0, `rsp_valid` = 0 and `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (14) | Word address |
| req_wdata | input | DW (4) | Write data |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | DW (4) | Read data |
| sram_addr | output | AW (14) | RAM address |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_dq_out | output | DW (4) | Data the block drives onto the RAM bus |
| sram_dq_oe | output | 1 | Enable for the block's bus drivers |
| sram_dq_in | input | DW (4) | Data sampled from the RAM bus |

## Verification
The hardest case to reach from the ports is a request raised while an earlier access is still in its strobe or recovery cycles. The request must wait without moving the address or the strobes, and it must then be taken on the first free cycle. The stimulus raises each request right after the previous one is accepted, with no gap, and only some requests get idle gaps. The second hard case is reading too early. The bench's RAM model presents the inverted word until chip select has been low for the full access count, so capture even one cycle early returns the wrong data. Back-to-back write-then-read pairs to the same address, and reads of addresses 0 and 16383, cover the data path.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_RECOVER,
    PH_TURN
  } sram_phase_e;

  function automatic int unsigned cyc_max5(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d,
                                           input int unsigned e);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/sram_cyc_timer.sv
module sram_cyc_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R2: a freshly loaded nonzero count cannot finish on the next cycle
  p_count_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> !done);
endmodule

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int WP_CYC    = 2,
  parameter int RD_CYC    = 3,
  parameter int REC_CYC   = 1,
  parameter int TA_CYC    = 1,
  parameter int CW        = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          is_wr,
  input  logic          done,
  output sram_phase_e   phase_q,
  output sram_phase_e   phase_d,
  output logic          load,
  output logic [CW-1:0] load_val
);
  localparam logic [CW-1:0] L_SETUP = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] L_WP    = CW'(WP_CYC - 1);
  localparam logic [CW-1:0] L_RD    = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] L_REC   = CW'(REC_CYC - 1);
  localparam logic [CW-1:0] L_TA    = CW'(TA_CYC - 1);

  always_comb begin
    phase_d  = phase_q;
    load     = 1'b0;
    load_val = '0;
    unique case (phase_q)
      PH_IDLE: if (accept) begin
        phase_d = PH_SETUP; load = 1'b1; load_val = L_SETUP;
      end
      PH_SETUP: if (done) begin
        phase_d = PH_STROBE; load = 1'b1; load_val = is_wr ? L_WP : L_RD;
      end
      PH_STROBE: if (done) begin
        load = 1'b1;
        if (is_wr) begin phase_d = PH_RECOVER; load_val = L_REC; end
        else       begin phase_d = PH_TURN;    load_val = L_TA;  end
      end
      PH_RECOVER, PH_TURN: if (done) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  // R2: the strobe phase is only ever entered from the setup phase
  p_strobe_after_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_STROBE && $past(phase_q) != PH_STROBE) |-> $past(phase_q) == PH_SETUP);
  // R6: recovery follows only a write window
  p_recover_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RECOVER && $past(phase_q) == PH_STROBE) |-> is_wr);
endmodule

// File: rtl/sram_pin_path.sv
module sram_pin_path
  import sram_ctrl_pkg::*;
#(
  parameter int AW = 14,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  sram_phase_e   phase_q,
  input  sram_phase_e   phase_d,
  input  logic          done,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          wr_q,
  output logic          oe_q,
  output logic          rsp_valid_q,
  output logic [DW-1:0] rdata_q
);
  logic capture;
  assign capture = (phase_q == PH_STROBE) && !wr_q && done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      wr_q    <= req_write;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_q        <= 1'b0;
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
    end else begin
      oe_q        <= wr_q && ((phase_d == PH_STROBE) ||
                              (phase_q == PH_STROBE && phase_d == PH_RECOVER));
      rsp_valid_q <= capture;
      if (capture) rdata_q <= dq_in;
    end
  end

  // R5: drivers never switch on in the same cycle as a read strobe
  p_oe_write_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> wr_q);
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW        = 14,
  parameter int DW        = 4,
  parameter int SETUP_CYC = 1,
  parameter int WP_CYC    = 2,
  parameter int RD_CYC    = 3,
  parameter int REC_CYC   = 1,
  parameter int TA_CYC    = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] sram_addr,
  output logic          sram_cs_n,
  output logic          sram_we_n,
  output logic [DW-1:0] sram_dq_out,
  output logic          sram_dq_oe,
  input  logic [DW-1:0] sram_dq_in
);
  localparam int MAXC = int'(cyc_max5(SETUP_CYC, WP_CYC, RD_CYC, REC_CYC, TA_CYC));
  localparam int CW   = $clog2(MAXC) + 1;

  sram_phase_e   phase_q, phase_d;
  logic          accept, done, load, wr_q;
  logic [CW-1:0] load_val;

  assign req_ready = (phase_q == PH_IDLE);
  assign accept    = req_valid && req_ready;

  sram_cyc_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .done(done)
  );

  sram_phase_fsm #(
    .SETUP_CYC(SETUP_CYC), .WP_CYC(WP_CYC), .RD_CYC(RD_CYC),
    .REC_CYC(REC_CYC), .TA_CYC(TA_CYC), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .is_wr(wr_q), .done(done),
    .phase_q(phase_q), .phase_d(phase_d), .load(load), .load_val(load_val)
  );

  sram_pin_path #(.AW(AW), .DW(DW)) u_pins (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .phase_q(phase_q),
    .phase_d(phase_d), .done(done), .dq_in(sram_dq_in), .addr_q(sram_addr),
    .wdata_q(sram_dq_out), .wr_q(wr_q), .oe_q(sram_dq_oe),
    .rsp_valid_q(rsp_valid), .rdata_q(rsp_rdata)
  );

  assign sram_cs_n = (phase_q != PH_STROBE);
  assign sram_we_n = !((phase_q == PH_STROBE) && wr_q);

  // R3: address frozen across consecutive selected cycles
  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));
  // R2: address moves only while deselected, straight after acceptance
  p_addr_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sram_addr) |-> (sram_cs_n && sram_we_n && $past(req_ready)));
  // R4: write enable is low only inside chip select and falls with it
  p_we_inside_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_cs_n);
  p_we_cs_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> $fell(sram_cs_n));
  // R5: no drive during a read, drive during every write cycle
  p_no_drive_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && sram_we_n) |-> !sram_dq_oe);
  p_drive_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> sram_dq_oe);
  // R8: response is a single-cycle pulse
  p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R1: busy while the RAM is selected
  p_busy_selected_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_cs_n |-> !req_ready);
endmodule

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;
  localparam int AW = 14, DW = 4;
  localparam int S = 2, WP = 2, RD = 3, REC = 2, TA = 1;
  localparam int LIMIT = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0, sram_dq_in = '0;
  logic req_ready, rsp_valid, sram_cs_n, sram_we_n, sram_dq_oe;
  logic [DW-1:0] rsp_rdata, sram_dq_out;
  logic [AW-1:0] sram_addr;

  always #5 clk = ~clk;

  sram_async_ctrl #(.AW(AW), .DW(DW), .SETUP_CYC(S), .WP_CYC(WP), .RD_CYC(RD),
                    .REC_CYC(REC), .TA_CYC(TA)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  typedef struct {
    bit ready; bit cs_n; bit we_n; bit oe; bit [3:0] dq;
    bit rsp; bit [3:0] rd; bit chk_addr; bit [13:0] addr; string tag;
  } exp_t;
  typedef struct { bit wr; bit [13:0] addr; bit [3:0] data; int gap; } req_t;

  exp_t exp_q[$];
  req_t req_q[$];
  logic [3:0] shadow[int];
  logic [3:0] ram[int];
  int checks = 0, failures = 0, cycles = 0;

  bit prev_cs_n = 1'b1, prev_ov = 1'b0;
  bit [13:0] prev_addr = '0;
  bit [3:0] last_d = '0;
  int acc = 0;

  task automatic chk(string tag, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", tag, what, act, expv, cycles);
    end
  endtask

  function automatic exp_t mk(bit cs_n, bit we_n, bit oe, bit [3:0] dq, bit [13:0] a, string tag);
    exp_t e;
    e.ready = 0; e.cs_n = cs_n; e.we_n = we_n; e.oe = oe; e.dq = dq;
    e.rsp = 0; e.rd = 0; e.chk_addr = 1; e.addr = a; e.tag = tag;
    return e;
  endfunction

  function automatic logic [3:0] ram_rd(bit [13:0] a);
    return ram.exists(int'(a)) ? ram[int'(a)] : 4'h0;
  endfunction

  task automatic push_timeline(req_t r);
    exp_t e;
    for (int i = 0; i < S; i++) exp_q.push_back(mk(1, 1, 0, 0, r.addr, "R2"));
    if (r.wr) begin
      shadow[int'(r.addr)] = r.data;
      for (int i = 0; i < WP; i++) exp_q.push_back(mk(0, 0, 1, r.data, r.addr, "R4"));
      for (int i = 0; i < REC; i++) exp_q.push_back(mk(1, 1, i == 0, r.data, r.addr, "R6"));
    end else begin
      for (int i = 0; i < RD; i++) exp_q.push_back(mk(0, 1, 0, 0, r.addr, "R7"));
      for (int i = 0; i < TA; i++) begin
        e = mk(1, 1, 0, 0, r.addr, "R9");
        if (i == 0) begin
          e.rsp = 1;
          e.rd = shadow.exists(int'(r.addr)) ? shadow[int'(r.addr)] : 4'h0;
        end
        exp_q.push_back(e);
      end
    end
  endtask

  task automatic step();
    exp_t e;
    bit cur_idle, ov;
    @(negedge clk);
    cycles++;
    if (exp_q.size() > 0) begin e = exp_q.pop_front(); cur_idle = 0; end
    else begin
      e = mk(1, 1, 0, 0, 0, "R1"); e.ready = 1; e.chk_addr = 0; cur_idle = 1;
    end
    chk("R1", "req_ready", req_ready, e.ready);
    chk(e.tag, "sram_cs_n", sram_cs_n, e.cs_n);
    chk(e.tag, "sram_we_n", sram_we_n, e.we_n);
    chk("R5", "sram_dq_oe", sram_dq_oe, e.oe);
    if (e.oe) chk("R5", "sram_dq_out", sram_dq_out, e.dq);
    chk("R8", "rsp_valid", rsp_valid, e.rsp);
    if (e.rsp) chk("R8", "rsp_rdata", rsp_rdata, e.rd);
    if (e.chk_addr) chk(e.tag, "sram_addr", sram_addr, e.addr);

    // behavioural RAM: protocol watch, write commit, delayed read data
    ov = !sram_cs_n && !sram_we_n;
    if (!sram_cs_n && !prev_cs_n) chk("R3", "addr moved in strobe", sram_addr, prev_addr);
    chk("R5", "bus contention", int'(sram_dq_oe && !sram_cs_n && sram_we_n), 0);
    if (ov) last_d = sram_dq_out;
    if (prev_ov && !ov) ram[int'(prev_addr)] = last_d;
    if (!sram_cs_n && sram_we_n) acc++; else acc = 0;
    sram_dq_in = (acc >= RD) ? ram_rd(sram_addr) : ~ram_rd(sram_addr);
    prev_cs_n = sram_cs_n; prev_ov = ov; prev_addr = sram_addr;

    // host driver: valid held until ready (R1 back-pressure)
    req_valid = 1'b0;
    if (req_q.size() > 0) begin
      if (req_q[0].gap > 0) req_q[0].gap--;
      else begin
        req_valid = 1'b1; req_write = req_q[0].wr;
        req_addr = req_q[0].addr; req_wdata = req_q[0].data;
        if (cur_idle) push_timeline(req_q.pop_front());
      end
    end
  endtask

  task automatic add(bit wr, bit [13:0] a, bit [3:0] d, int gap);
    req_t r;
    r.wr = wr; r.addr = a; r.data = d; r.gap = gap;
    req_q.push_back(r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "cs_n in reset", sram_cs_n, 1);
    chk("R10", "we_n in reset", sram_we_n, 1);
    chk("R10", "oe in reset", sram_dq_oe, 0);
    chk("R10", "rsp_valid in reset", rsp_valid, 0);
    chk("R10", "req_ready in reset", req_ready, 1);
    rst_n = 1'b1;

    // boundary addresses, write then read back (R4 R6 R7 R8 R9)
    add(1, 14'd0, 4'hA, 2);
    add(1, 14'h3FFF, 4'h5, 0);
    add(0, 14'd0, 0, 0);
    add(0, 14'h3FFF, 0, 3);
    add(0, 14'h1234, 0, 0);          // never written: reads 0
    add(1, 14'h2AAA, 4'hF, 0);
    add(0, 14'h2AAA, 0, 0);          // back-to-back same address
    add(1, 14'h2AAA, 4'h3, 1);       // overwrite
    add(0, 14'h2AAA, 0, 0);
    for (int i = 0; i < 40; i++)
      add(i % 3 != 2, 14'((i * 1237) % 16384), 4'(i ^ 9), i % 4);
    for (int i = 0; i < 40; i++)
      add(0, 14'((i * 1237) % 16384), 0, (i % 5 == 0) ? 1 : 0);

    while ((req_q.size() > 0 || exp_q.size() > 0) && cycles < LIMIT) step();
    if (cycles >= LIMIT) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, LIMIT);
    end
    repeat (3) step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule